// File: doc/BRIEF.md
# Search-Mode Envelope Label/Virgin Detector and Speed Meter

This block runs while a tape transport is fast-winding in search mode. It takes one bit: the sliced envelope of the auxiliary track. From that bit it reports two region flags. The label flag means the envelope has stayed present over a long run. The virgin flag means the envelope has stayed absent over a long run. A block tick marks each auxiliary-block interval, and the run lengths are counted in those ticks.

The block also measures the time between rising envelope edges, in clock cycles, and turns it into a tape-speed word. The word has a 5-bit count, a 2-bit range and an invalid flag. The relative speed is 51.2 · 2^range / count. The count increments once per prescale step of 2^(UNIT_LOG2 − range) clock cycles, so one count spans fewer cycles at a higher range. After each measurement the range moves up or down by one step, which keeps the count inside its working area.

Top module: `envelope_search_detector`

## Requirements
- R1: While search_en is low, label_flag, virgin_flag, env_out, speed_count and speed_range are all 0 and speed_invalid is 1. All internal run and period state is cleared, and the same holds in reset.
- R2: While search_en is high, env_out equals env_in in the same cycle.
- R3: A high-run counter counts blk_tick pulses seen while env_in is high. It saturates at BLOCK_THRESH (default 8) and clears in any cycle where env_in is low. label_flag rises on the clock edge that follows the edge on which this counter reaches BLOCK_THRESH.
- R4: label_flag falls on the edge that follows the edge on which the low-run counter reaches BLOCK_THRESH. The low-run counter counts ticks while env_in is low and clears while env_in is high.
- R5: virgin_flag rises in the cycle where the low-run counter is full, by the same rule as R4. It falls in the cycle where the high-run counter is full, by the same rule as R3.
- R6: label_flag and virgin_flag are never high together.
- R7: A rising edge of env_in is seen on the first edge where env_in is high after a cycle in which it was low; the cycle when search mode begins counts as low. P is the number of clock edges between two such detections. On the second detection, speed_count becomes min(floor((P−1) / 2^(UNIT_LOG2−r)), 31), where r is the range in force, and speed_range becomes r. The first detection after entering search mode publishes nothing.
- R8: When a published count is 0 and r is below 3, the range for the next measurement is r+1.
- R9: When a published count is above HI_LIMIT (default 17) and r is above 0, the range for the next measurement is r−1.
- R10: speed_invalid is 1 in any of these cases: no measurement has been published yet, label_flag is low, the last count was 0 at range 3, or the last count was 31 at range 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| search_en | input | 1 | Search-mode enable; low clears and silences the block |
| env_in | input | 1 | Sliced auxiliary-track envelope bit |
| blk_tick | input | 1 | One-cycle pulse per auxiliary-block interval |
| env_out | output | 1 | Envelope gated by search mode |
| label_flag | output | 1 | Label region detected |
| virgin_flag | output | 1 | Unrecorded tape detected |
| speed_count | output | 5 | Measured period count |
| speed_range | output | 2 | Range used for speed_count |
| speed_invalid | output | 1 | Speed word is meaningless when high |

## Verification
env_out is combinational, so it is due in the same cycle as its input. The label and virgin flags are due one edge after the run counter saturates. Each speed field is due on the edge that detects the rising envelope, and the range it produces applies from the next prescale step onward. The bench drives inputs on the falling edge. A cycle-level reference model updates on every rising edge, and all outputs are compared with it 3 ns after that edge, so each result is compared in the cycle it is due. Directed phases pick envelope periods whose counts can be worked out by hand (5, 0, 1, saturated) and check those numbers after the last captured period, while the output holds steady.

// File: rtl/env_det_pkg.sv
// Shared widths, types and the range-steering rule for the envelope detector.
package env_det_pkg;
    localparam int CNT_W = 5;
    localparam int RNG_W = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [RNG_W-1:0] rng_t;

    localparam cnt_t CNT_MAX = '1;
    localparam rng_t RNG_MAX = '1;

    // Pick the range for the next measurement from the count just published.
    function automatic rng_t next_range(input cnt_t cnt, input rng_t rng, input cnt_t hi_lim);
        if (cnt == '0 && rng != RNG_MAX)
            return rng + rng_t'(1);
        else if (cnt > hi_lim && rng != '0)
            return rng - rng_t'(1);
        else
            return rng;
    endfunction
endpackage

// File: rtl/env_run_counter.sv
// Counts block ticks while the envelope sits at LEVEL. It saturates at THRESH
// and clears whenever the envelope leaves LEVEL or the block is disabled.
// Assumes blk_tick is a single-cycle pulse.
module env_run_counter #(
    parameter int   THRESH = 8,
    parameter logic LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic env_in,
    input  logic blk_tick,
    output logic full
);
    localparam int RW = $clog2(THRESH + 1);
    localparam logic [RW-1:0] LIMIT = RW'(THRESH);

    logic [RW-1:0] run_q;

    // Run-length counter for one envelope level.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            run_q <= '0;
        else if (env_in != LEVEL)
            run_q <= '0;
        else if (blk_tick && run_q != LIMIT)
            run_q <= run_q + RW'(1);
    end

    assign full = (run_q == LIMIT);

    // The run is cleared one edge after the envelope leaves LEVEL (R3, R4).
    p_run_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && env_in != LEVEL) |=> (run_q == '0));
endmodule

// File: rtl/env_period_meter.sv
// Measures the clock-cycle spacing of rising envelope edges with a prescaler
// whose step is 2^(UNIT_LOG2-range) cycles. It publishes count and range on
// each edge after the first, then steers the range by one step.
// Assumes UNIT_LOG2 >= the top range (3).
module env_period_meter
    import env_det_pkg::*;
#(
    parameter int UNIT_LOG2 = 5,
    parameter int HI_LIMIT  = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic env_in,
    output cnt_t cnt_out,
    output rng_t rng_out,
    output logic bad_out
);
    localparam int   PRE_W = UNIT_LOG2;
    localparam cnt_t HI_LIM = cnt_t'(HI_LIMIT);

    logic             env_d;
    logic             have_prev;
    logic             rise;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] step_last;
    logic [PRE_W:0]   step_len;
    logic [7:0]       shamt;
    cnt_t             per_q;
    rng_t             range_q;

    // Prescale step length for the range in force.
    always_comb begin
        shamt     = 8'(UNIT_LOG2) - 8'(range_q);
        step_len  = (PRE_W+1)'(1) << shamt;
        step_last = PRE_W'(step_len - (PRE_W+1)'(1));
    end

    assign rise = env_in && !env_d;

    // Edge detection, prescaling, capture and range steering.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            env_d     <= 1'b0;
            have_prev <= 1'b0;
            pre_q     <= '0;
            per_q     <= '0;
            range_q   <= '0;
            cnt_out   <= '0;
            rng_out   <= '0;
            bad_out   <= 1'b1;
        end else begin
            env_d <= env_in;
            if (rise) begin
                if (have_prev) begin
                    cnt_out <= per_q;
                    rng_out <= range_q;
                    bad_out <= (per_q == '0 && range_q == RNG_MAX) ||
                               (per_q == CNT_MAX && range_q == '0);
                    range_q <= next_range(per_q, range_q, HI_LIM);
                end
                have_prev <= 1'b1;
                pre_q     <= '0;
                per_q     <= '0;
            end else if (pre_q == step_last) begin
                pre_q <= '0;
                if (per_q != CNT_MAX)
                    per_q <= per_q + cnt_t'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // A zero count below the top range raises the range by one (R8).
    p_range_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise && have_prev && per_q == '0 && range_q != RNG_MAX)
        |=> (!enable || range_q == $past(range_q) + rng_t'(1)));

    // A count above the limit above the bottom range lowers it by one (R9).
    p_range_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise && have_prev && per_q > HI_LIM && range_q != '0)
        |=> (!enable || range_q == $past(range_q) - rng_t'(1)));

    // The range only moves on a capture edge (R7).
    p_range_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !rise) |=> (!enable || $stable(range_q)));
endmodule

// File: rtl/envelope_search_detector.sv
// Search-mode envelope detector. Two run counters (high and low level) drive
// the mutually exclusive label and virgin flags. A period meter produces the
// auto-ranging speed word. Everything is quiet and cleared outside search mode.
// Assumes env_in is already synchronous to clk and blk_tick is a one-cycle pulse.
module envelope_search_detector
    import env_det_pkg::*;
#(
    parameter int BLOCK_THRESH = 8,
    parameter int UNIT_LOG2    = 5,
    parameter int HI_LIMIT     = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             search_en,
    input  logic             env_in,
    input  logic             blk_tick,
    output logic             env_out,
    output logic             label_flag,
    output logic             virgin_flag,
    output logic [CNT_W-1:0] speed_count,
    output logic [RNG_W-1:0] speed_range,
    output logic             speed_invalid
);
    logic [1:0] run_full;   // [1] high-level run full, [0] low-level run full
    logic       label_q;
    logic       virgin_q;
    logic       bad_q;

    // One run counter per envelope level.
    for (genvar g = 0; g < 2; g++) begin : g_run
        env_run_counter #(
            .THRESH (BLOCK_THRESH),
            .LEVEL  (g[0])
        ) u_run (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (search_en),
            .env_in   (env_in),
            .blk_tick (blk_tick),
            .full     (run_full[g])
        );
    end

    // Region flags: a full high run means label, a full low run means virgin.
    always_ff @(posedge clk) begin
        if (!rst_n || !search_en) begin
            label_q  <= 1'b0;
            virgin_q <= 1'b0;
        end else if (run_full[1]) begin
            label_q  <= 1'b1;
            virgin_q <= 1'b0;
        end else if (run_full[0]) begin
            label_q  <= 1'b0;
            virgin_q <= 1'b1;
        end
    end

    env_period_meter #(
        .UNIT_LOG2 (UNIT_LOG2),
        .HI_LIMIT  (HI_LIMIT)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (search_en),
        .env_in  (env_in),
        .cnt_out (speed_count),
        .rng_out (speed_range),
        .bad_out (bad_q)
    );

    assign env_out       = env_in && search_en;
    assign label_flag    = label_q;
    assign virgin_flag   = virgin_q;
    assign speed_invalid = bad_q || !label_q;

    // Never both region flags at once (R6).
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(label_flag && virgin_flag));

    // Leaving search mode silences the flags on the next edge (R1).
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> (!label_flag && !virgin_flag));

    // Label only rises after a full high run (R3).
    p_label_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(label_flag) |-> $past(run_full[1]));

    // Virgin only rises after a full low run (R5).
    p_virgin_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(virgin_flag) |-> $past(run_full[0]));
endmodule

// File: tb/envelope_search_detector_tb.sv
module envelope_search_detector_tb;
    localparam int TH   = 8;
    localparam int UL   = 5;
    localparam int HLIM = 17;

    logic       clk = 1'b0;
    logic       rst_n, search_en, env_in, blk_tick;
    logic       env_out, label_flag, virgin_flag, speed_invalid;
    logic [4:0] speed_count;
    logic [1:0] speed_range;

    envelope_search_detector #(.BLOCK_THRESH(TH), .UNIT_LOG2(UL), .HI_LIMIT(HLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .env_in(env_in),
        .blk_tick(blk_tick), .env_out(env_out), .label_flag(label_flag),
        .virgin_flag(virgin_flag), .speed_count(speed_count),
        .speed_range(speed_range), .speed_invalid(speed_invalid));

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    int tcnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Block tick: one pulse every 4 cycles.
    always @(negedge clk) begin
        blk_tick <= (tcnt == 3);
        tcnt     <= (tcnt + 1) % 4;
    end

    // Reference model state, updated on each rising edge.
    int m_hr, m_lr, m_cyc, m_last, m_rng_cur, m_cnt, m_rng;
    bit m_lab, m_vir, m_envd, m_havep, m_bad;

    always @(posedge clk) begin
        if (!rst_n || !search_en) begin
            m_hr = 0; m_lr = 0; m_lab = 0; m_vir = 0; m_envd = 0; m_havep = 0;
            m_rng_cur = 0; m_cnt = 0; m_rng = 0; m_bad = 1; m_cyc = 0; m_last = 0;
        end else begin
            m_cyc++;
            if (m_hr == TH) begin m_lab = 1; m_vir = 0; end
            else if (m_lr == TH) begin m_lab = 0; m_vir = 1; end
            if (env_in) begin
                m_lr = 0;
                if (blk_tick && m_hr < TH) m_hr++;
            end else begin
                m_hr = 0;
                if (blk_tick && m_lr < TH) m_lr++;
            end
            if (env_in && !m_envd) begin
                if (m_havep) begin
                    int p, c;
                    p = m_cyc - m_last;
                    c = (p - 1) >> (UL - m_rng_cur);
                    if (c > 31) c = 31;
                    m_cnt = c;
                    m_rng = m_rng_cur;
                    m_bad = (c == 0 && m_rng_cur == 3) || (c == 31 && m_rng_cur == 0);
                    if (c == 0 && m_rng_cur < 3) m_rng_cur++;
                    else if (c > HLIM && m_rng_cur > 0) m_rng_cur--;
                end
                m_havep = 1;
                m_last  = m_cyc;
            end
            m_envd = env_in;
        end
    end

    // Compare every output with the model shortly after each rising edge.
    always begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            chk(env_out == (env_in && search_en), "R2 env_out", env_out, env_in && search_en);
            chk(label_flag == m_lab, "R3/R4 label_flag", label_flag, m_lab);
            chk(virgin_flag == m_vir, "R5 virgin_flag", virgin_flag, m_vir);
            chk(!(label_flag && virgin_flag), "R6 exclusive", label_flag && virgin_flag, 0);
            chk(speed_count == m_cnt, "R7 speed_count", speed_count, m_cnt);
            chk(speed_range == m_rng, "R7 speed_range", speed_range, m_rng);
            chk(speed_invalid == (m_bad || !m_lab), "R10 speed_invalid",
                speed_invalid, m_bad || !m_lab);
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_periods(input int hi, input int lo, input int n);
        for (int i = 0; i < n; i++) begin
            env_in = 1'b1; hold(hi);
            env_in = 1'b0; hold(lo);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int seed_d;
        seed_d = $urandom(32'd1234);
        rst_n = 1'b0; search_en = 1'b0; env_in = 1'b0;
        hold(3);
        chk(!label_flag && !virgin_flag && !env_out, "R1 reset flags", label_flag, 0);
        chk(speed_count == 0 && speed_range == 0 && speed_invalid, "R1 reset speed", speed_count, 0);
        rst_n = 1'b1;
        env_in = 1'b1; hold(40);
        chk(!label_flag && !env_out, "R1 off ignores env", label_flag, 0);
        env_in = 1'b0;

        search_en = 1'b1;
        hold(40);
        chk(virgin_flag == 1, "R5 virgin set", virgin_flag, 1);
        env_in = 1'b1; hold(40);
        chk(label_flag == 1, "R3 label set", label_flag, 1);
        chk(virgin_flag == 0, "R5 virgin cleared", virgin_flag, 0);

        run_periods(151, 10, 3);
        chk(speed_count == 5, "R7 count P=161", speed_count, 5);
        chk(speed_range == 0, "R7 range 0", speed_range, 0);
        chk(speed_invalid == 0, "R10 valid", speed_invalid, 0);

        run_periods(15, 5, 2);
        chk(speed_count == 0, "R8 zero count", speed_count, 0);
        run_periods(15, 5, 2);
        chk(speed_count == 1, "R8 count after up", speed_count, 1);
        chk(speed_range == 1, "R8 range up", speed_range, 1);

        run_periods(2, 2, 6);
        chk(speed_range == 3 && speed_count == 0, "R8 top range", speed_range, 3);
        chk(speed_invalid == 1, "R10 zero at top", speed_invalid, 1);

        run_periods(1490, 10, 6);
        chk(speed_range == 0 && speed_count == 31, "R9 down to 0", speed_range, 0);
        chk(speed_invalid == 1, "R10 sat at bottom", speed_invalid, 1);

        env_in = 1'b0; hold(50);
        chk(label_flag == 0, "R4 label cleared", label_flag, 0);
        chk(virgin_flag == 1, "R5 virgin after low", virgin_flag, 1);
        chk(speed_invalid == 1, "R10 no label", speed_invalid, 1);

        search_en = 1'b0; env_in = 1'b1; hold(2);
        chk(!label_flag && !virgin_flag && !env_out, "R1 off flags", virgin_flag, 0);
        chk(speed_count == 0 && speed_range == 0 && speed_invalid, "R1 off speed", speed_count, 0);
        search_en = 1'b1;

        for (int k = 0; k < 200; k++) begin
            int hi, lo;
            hi = $urandom_range(120, 1);
            lo = ($urandom_range(9, 0) == 0) ? $urandom_range(80, 40) : $urandom_range(30, 1);
            if ($urandom_range(29, 0) == 0) begin
                search_en = 1'b0; hold($urandom_range(4, 1)); search_en = 1'b1;
            end
            run_periods(hi, lo, 1);
        end
        finish_run();
    end
endmodule